// File: doc/BRIEF.md
# Harmonic Time Word Converter

This block takes a 64-bit harmonic time word and reports the period and the phase that the word encodes. It also translates the word between two harmonic formats whose one-second bit sits at different positions. In a harmonic word the highest set bit marks the period, which is a power of two of one second. The bits below that bit, read as a binary number, give the phase within the period. The fine on-chip format places one second at bit 32. The coarse network format places it at bit 24. A translation is therefore a shift by 8 that lines up the two one-second bits.

A translated instant is kept only if it lies in the part of the range that both formats share. That shared part has the shorter horizon and the coarser step of the two formats. If bits would be lost, the block raises an out-of-range flag. The block is combinational, and a parameter can add one register stage at its output. The default has the register, which gives a latency of one cycle. An all-zero word has no period bit, so the block reports it as not valid.

Top module: `htc_convert`

## Requirements
- R1: For a non-zero input, `period_idx` gives the bit index of the highest set bit of `in_word`.
- R2: For a non-zero input, `phase` equals `in_word` with its period bit cleared. The result is the bits below the period bit.
- R3: An all-zero `in_word` gives `valid`=0, `period_idx`=0, `phase`=0, `conv_word`=0 and `out_of_range`=0, in both directions. Any non-zero word gives `valid`=1.
- R4: With `dir`=0 (fine to coarse), `conv_word` equals `in_word` shifted right by 8.
- R5: With `dir`=0, `out_of_range` is 1 exactly when any of bits 7..0 of `in_word` is set. This covers every word whose period bit lies below bit 8.
- R6: With `dir`=1 (coarse to fine), `conv_word` equals `in_word` shifted left by 8, and bits shifted past bit 63 are dropped.
- R7: With `dir`=1, `out_of_range` is 1 exactly when any of bits 63..56 of `in_word` is set.
- R8: With the output register enabled (the default), every output follows the input one clock later. An active-low reset clears all outputs to 0.
- R9: A fine word that converts without the out-of-range flag converts back to the original word when passed through the coarse-to-fine direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_word | input | 64 | Harmonic time word to decode and convert |
| dir | input | 1 | 0: fine to coarse, 1: coarse to fine |
| period_idx | output | 6 | Index of the period bit |
| phase | output | 64 | Phase value below the period bit |
| valid | output | 1 | Input word has a period bit |
| conv_word | output | 64 | Word translated to the other format |
| out_of_range | output | 1 | Translation lost bits outside the shared range |

## Verification
The block holds no internal state apart from the output register. A fault in the priority search or in the shift therefore appears on the ports one cycle after the word that exposes it. Such a fault shows as a wrong period index, a phase that still holds the period bit, or a flag that disagrees with the discarded bits. The test words place the period bit at both ends of the word, at both one-second positions and next to the shift boundary. A round trip through both directions checks that the two shift amounts match.

// File: rtl/htc_pkg.sv
package htc_pkg;
    localparam int WORD_W     = 64;
    localparam int FINE_SEC   = 32;
    localparam int COARSE_SEC = 24;
    localparam int IDX_W      = $clog2(WORD_W);

    typedef enum logic {
        DIR_FINE_TO_COARSE = 1'b0,
        DIR_COARSE_TO_FINE = 1'b1
    } dir_e;
endpackage

// File: rtl/htc_period_find.sv
module htc_period_find #(
    parameter int W     = 64,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     word,
    output logic [IDX_W-1:0] idx,
    output logic             found,
    output logic [W-1:0]     below
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (word[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
        below = found ? (word & ~({{(W-1){1'b0}}, 1'b1} << idx)) : '0;
    end
endmodule

// File: rtl/htc_align.sv
module htc_align #(
    parameter int W     = 64,
    parameter int SHIFT = 8
) (
    input  logic [W-1:0] word,
    input  logic         to_fine,
    output logic [W-1:0] conv,
    output logic         lost
);
    localparam logic [W-1:0] LOW_MASK  = ({{(W-1){1'b0}}, 1'b1} << SHIFT) - 1'b1;
    localparam logic [W-1:0] HIGH_MASK = ~({W{1'b1}} >> SHIFT);

    always_comb begin
        if (to_fine) begin
            conv = word << SHIFT;
            lost = |(word & HIGH_MASK);
        end else begin
            conv = word >> SHIFT;
            lost = |(word & LOW_MASK);
        end
    end
endmodule

// File: rtl/htc_convert.sv
module htc_convert #(
    parameter int W          = htc_pkg::WORD_W,
    parameter int FINE_SEC   = htc_pkg::FINE_SEC,
    parameter int COARSE_SEC = htc_pkg::COARSE_SEC,
    parameter bit OUT_REG    = 1'b1,
    localparam int IDX_W     = $clog2(W),
    localparam int SHIFT     = FINE_SEC - COARSE_SEC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     in_word,
    input  logic             dir,
    output logic [IDX_W-1:0] period_idx,
    output logic [W-1:0]     phase,
    output logic             valid,
    output logic [W-1:0]     conv_word,
    output logic             out_of_range
);
    logic [IDX_W-1:0] c_idx;
    logic [W-1:0]     c_phase;
    logic             c_valid;
    logic [W-1:0]     c_conv;
    logic             c_lost;

    htc_period_find #(.W(W), .IDX_W(IDX_W)) find_i (
        .word(in_word), .idx(c_idx), .found(c_valid), .below(c_phase)
    );

    htc_align #(.W(W), .SHIFT(SHIFT)) align_i (
        .word(in_word), .to_fine(dir == htc_pkg::DIR_COARSE_TO_FINE),
        .conv(c_conv), .lost(c_lost)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    period_idx   <= '0;
                    phase        <= '0;
                    valid        <= 1'b0;
                    conv_word    <= '0;
                    out_of_range <= 1'b0;
                end else begin
                    period_idx   <= c_idx;
                    phase        <= c_phase;
                    valid        <= c_valid;
                    conv_word    <= c_conv;
                    out_of_range <= c_lost;
                end
            end
        end else begin : g_comb
            assign period_idx   = c_idx;
            assign phase        = c_phase;
            assign valid        = c_valid;
            assign conv_word    = c_conv;
            assign out_of_range = c_lost;
        end
    endgenerate
endmodule

// File: rtl/htc_convert_chk.sv
module htc_convert_chk #(
    parameter int W       = 64,
    parameter int SHIFT   = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int IDX_W  = $clog2(W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     in_word,
    input logic             dir,
    input logic [IDX_W-1:0] period_idx,
    input logic [W-1:0]     phase,
    input logic             valid,
    input logic [W-1:0]     conv_word,
    input logic             out_of_range
);
    localparam logic [W-1:0] ONE       = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] LOW_MASK  = (ONE << SHIFT) - 1'b1;
    localparam logic [W-1:0] HIGH_MASK = ~({W{1'b1}} >> SHIFT);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    generate
        if (OUT_REG) begin : g_chk
            assert_period_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && valid) |-> (($past(in_word) >> period_idx) == ONE));
            assert_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && valid) |-> ((phase | (ONE << period_idx)) == $past(in_word)));
            assert_zero_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && $past(in_word) == '0) |-> (!valid && phase == '0 && !out_of_range));
            assert_f2c_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && !$past(dir)) |-> (out_of_range == |($past(in_word) & LOW_MASK)));
            assert_c2f_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && $past(dir)) |-> (out_of_range == |($past(in_word) & HIGH_MASK)));
            assert_conv_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && valid && !out_of_range) |-> (conv_word != '0));
        end
    endgenerate
endmodule

bind htc_convert htc_convert_chk #(.W(W), .SHIFT(SHIFT), .OUT_REG(OUT_REG)) chk_i (.*);

// File: tb/htc_convert_tb.sv
module htc_convert_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_word = '0;
    logic        dir = 1'b0;
    logic [5:0]  period_idx;
    logic [63:0] phase;
    logic        valid;
    logic [63:0] conv_word;
    logic        out_of_range;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    htc_convert dut_i (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .dir(dir),
        .period_idx(period_idx), .phase(phase), .valid(valid),
        .conv_word(conv_word), .out_of_range(out_of_range)
    );

    localparam int NV = 9;
    localparam logic [63:0] V_IN [NV] = '{
        64'h0000_0001_0000_0000, 64'h0000_0001_8000_0000, 64'h0000_0000_0000_01FF,
        64'h0000_0000_0000_0080, 64'h0000_0000_0100_0000, 64'h0100_0000_0000_0000,
        64'h00FF_0000_0000_0003, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF00};
    localparam logic V_DIR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic [5:0] V_IDX [NV] = '{6'd32, 6'd32, 6'd8, 6'd7, 6'd24, 6'd56, 6'd55, 6'd63, 6'd63};
    localparam logic [63:0] V_PH [NV] = '{
        64'h0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_00FF,
        64'h0, 64'h0, 64'h0,
        64'h007F_0000_0000_0003, 64'h0, 64'h7FFF_FFFF_FFFF_FF00};
    localparam logic [63:0] V_CONV [NV] = '{
        64'h0000_0000_0100_0000, 64'h0000_0000_0180_0000, 64'h0000_0000_0000_0001,
        64'h0, 64'h0000_0001_0000_0000, 64'h0,
        64'hFF00_0000_0000_0300, 64'h0080_0000_0000_0000, 64'h00FF_FFFF_FFFF_FFFF};
    localparam logic V_OOR [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] w, input logic d);
        @(negedge clk);
        in_word = w;
        dir = d;
        @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        logic [63:0] mid;
        in_word = 64'h0000_0001_8000_0000;
        repeat (3) @(negedge clk);
        // R8: outputs held clear during reset
        check("R8 reset valid", 64'(valid), 64'h0);
        check("R8 reset conv", conv_word, 64'h0);
        check("R8 reset phase", phase, 64'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(V_IN[k], V_DIR[k]);
            check("R1 period_idx", 64'(period_idx), 64'(V_IDX[k]));
            check("R2 phase", phase, V_PH[k]);
            check("R3 valid", 64'(valid), 64'h1);
            check(V_DIR[k] ? "R6 conv" : "R4 conv", conv_word, V_CONV[k]);
            check(V_DIR[k] ? "R7 out_of_range" : "R5 out_of_range", 64'(out_of_range), 64'(V_OOR[k]));
        end

        // R3: zero word in both directions
        for (int d = 0; d < 2; d++) begin
            apply(64'h0, d[0]);
            check("R3 zero valid", 64'(valid), 64'h0);
            check("R3 zero idx", 64'(period_idx), 64'h0);
            check("R3 zero phase", phase, 64'h0);
            check("R3 zero conv", conv_word, 64'h0);
            check("R3 zero oor", 64'(out_of_range), 64'h0);
        end

        // R8: latency of exactly one clock
        @(negedge clk);
        in_word = 64'h0000_0000_0000_0400;
        dir = 1'b0;
        @(posedge clk);
        #1;
        check("R8 one-cycle latency", 64'(period_idx), 64'd10);

        // R9: round trip fine -> coarse -> fine
        apply(64'h0000_0123_4567_8900, 1'b0);
        check("R9 forward in range", 64'(out_of_range), 64'h0);
        mid = conv_word;
        apply(mid, 1'b1);
        check("R9 round trip", conv_word, 64'h0000_0123_4567_8900);

        // R8: asynchronous reset clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 async reset", conv_word, 64'h0);
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule